// File: doc/BRIEF.md
# Task Time-Slice Timer

This block is a per-processor down-counter that bounds how long one task may run before control is taken back. Software, or the hardware path that enters an interrupt procedure, loads it with a slice length. The value is held as six BCD digits. After that the counter drops by one on every timebase tick (1 ms by default), so a full count of 999999 lasts a little under a thousand seconds. Ticks are ignored while the processor runs in interrupting mode, so time spent servicing interrupts is not charged to the task.

There are two ways the slice can end. If the timer-interrupt mask bit is set, a level interrupt request rises once the top BCD digit has reached zero. The request stays up until the interrupt procedure is taken or a new slice is loaded. If the mask is clear, counting simply continues. If no interrupt procedure has been taken since the last load when the whole count hits zero, a sticky task-timer fault is raised as a backstop. A load clears that fault.

Top module: `task_slice_timer`

## Requirements
- R1: While reset is high, on the next clock edge the count becomes 000000 and both the interrupt request and the fault go low.
- R2: A load strobe makes the count equal the load value after the next clock edge. It also clears the interrupt request and the fault. A tick in the same cycle is ignored, so the loaded value is not decremented.
- R3: Each tick taken outside interrupting mode lowers the count by one in BCD. A borrow ripples through zero digits, for example 100000 goes to 099999 and 010000 goes to 009999.
- R4: While the interrupting-mode input is high, ticks leave the count unchanged.
- R5: The count saturates at 000000. A tick at zero leaves it at zero and never wraps.
- R6: With the mask bit set, the interrupt request rises one clock after the count's most significant digit (bits 23:20) reads zero. It stays high as a level. It fires at most once per loaded slice.
- R7: An interrupt-procedure-taken strobe drops the interrupt request after the next edge. The request does not come back before another load.
- R8: With the mask bit clear, no interrupt request is raised and counting goes on past the point where the top digit is zero.
- R9: The fault rises one clock after the count reads zero if no interrupt-procedure-taken strobe has occurred since the last load. It stays high until the next load.
- R10: An interrupt-procedure-taken strobe seen after a load suppresses the fault for that slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| intr_mode_i | input | 1 | Processor is in interrupting mode |
| irq_mask_i | input | 1 | Timer-interrupt mask bit (1 = enabled) |
| load_i | input | 1 | Load strobe for a new slice |
| load_val_i | input | 24 | Slice value, six BCD digits |
| proc_taken_i | input | 1 | Interrupt procedure taken strobe |
| irq_o | output | 1 | Timer interrupt request (level) |
| fault_o | output | 1 | Task-timer fault (sticky) |
| count_o | output | 24 | Current count, six BCD digits |

## Verification
Count updates, loads and the reset state appear one edge after the stimulus that causes them. The interrupt request and the fault are computed from the registered count, so they appear one edge later than the count change that triggers them. For example, the tick that clears the top digit is followed by an edge with no request and then an edge with the request high. The bench drives every input at the falling edge and samples at the next falling edge. Each table row is exactly one clock, and the expected values in each row are written with this one-cycle lag built in.

// File: rtl/tst_pkg.sv
package tst_pkg;

    localparam int BCD_W = 4;

    typedef struct packed {
        logic irq;
        logic irq_fired;
        logic proc_seen;
        logic fault;
    } ctl_state_t;

    // Decrement one BCD digit: returns {borrow_out, digit_out}
    function automatic logic [BCD_W:0] bcd_digit_dec(input logic [BCD_W-1:0] d,
                                                     input logic borrow_in);
        logic [BCD_W:0] r;
        if (!borrow_in) begin
            r = {1'b0, d};
        end else if (d == '0) begin
            r = {1'b1, 4'd9};
        end else begin
            r = {1'b0, d - 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/tst_count_reg.sv
module tst_count_reg
    import tst_pkg::*;
#(
    parameter int DIGITS = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [DIGITS*BCD_W-1:0]  load_val,
    input  logic                     dec_en,
    output logic [DIGITS*BCD_W-1:0]  count,
    output logic                     msd_zero,
    output logic                     all_zero
);
    localparam int W = DIGITS * BCD_W;

    logic [W-1:0]    cnt_q;
    logic [W-1:0]    cnt_dec;
    logic [DIGITS:0] borrow;

    assign borrow[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign {borrow[g+1], cnt_dec[g*BCD_W +: BCD_W]} =
            bcd_digit_dec(cnt_q[g*BCD_W +: BCD_W], borrow[g]);
    end

    assign all_zero = (cnt_q == '0);
    assign msd_zero = (cnt_q[W-1 -: BCD_W] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec_en && !all_zero) begin
            cnt_q <= cnt_dec;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/tst_slice_ctl.sv
module tst_slice_ctl
    import tst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic mask,
    input  logic taken,
    input  logic msd_zero,
    input  logic all_zero,
    output logic irq,
    output logic fault
);
    ctl_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            st_q <= '0;
        end else begin
            if (taken) begin
                st_q.irq       <= 1'b0;
                st_q.proc_seen <= 1'b1;
            end else if (mask && msd_zero && !st_q.irq_fired) begin
                st_q.irq       <= 1'b1;
                st_q.irq_fired <= 1'b1;
            end
            if (all_zero && !st_q.proc_seen && !taken) begin
                st_q.fault <= 1'b1;
            end
        end
    end

    assign irq   = st_q.irq;
    assign fault = st_q.fault;
endmodule

// File: rtl/task_slice_timer.sv
module task_slice_timer
    import tst_pkg::*;
#(
    parameter int DIGITS = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_i,
    input  logic                    intr_mode_i,
    input  logic                    irq_mask_i,
    input  logic                    load_i,
    input  logic [DIGITS*4-1:0]     load_val_i,
    input  logic                    proc_taken_i,
    output logic                    irq_o,
    output logic                    fault_o,
    output logic [DIGITS*4-1:0]     count_o
);
    logic msd_zero;
    logic all_zero;
    logic dec_en;

    assign dec_en = tick_i && !intr_mode_i;

    tst_count_reg #(.DIGITS(DIGITS)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (load_i),
        .load_val (load_val_i),
        .dec_en   (dec_en),
        .count    (count_o),
        .msd_zero (msd_zero),
        .all_zero (all_zero)
    );

    tst_slice_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .load     (load_i),
        .mask     (irq_mask_i),
        .taken    (proc_taken_i),
        .msd_zero (msd_zero),
        .all_zero (all_zero),
        .irq      (irq_o),
        .fault    (fault_o)
    );
endmodule

// File: rtl/tst_checker.sv
module tst_checker #(
    parameter int DIGITS = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                tick_i,
    input logic                intr_mode_i,
    input logic                irq_mask_i,
    input logic                load_i,
    input logic [DIGITS*4-1:0] load_val_i,
    input logic                proc_taken_i,
    input logic                irq_o,
    input logic                fault_o,
    input logic [DIGITS*4-1:0] count_o
);
    localparam int W = DIGITS * 4;

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (count_o == $past(load_val_i)) && !irq_o && !fault_o);

    p_intr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (intr_mode_i && !load_i) |=> $stable(count_o));

    p_saturate_r5: assert property (@(posedge clk) disable iff (rst)
        (count_o == '0 && !load_i) |=> (count_o == '0));

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(irq_mask_i) && ($past(count_o[W-1 -: 4]) == 4'd0)));

    p_taken_clears_r7: assert property (@(posedge clk) disable iff (rst)
        proc_taken_i |=> !irq_o);

    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_o && !load_i) |=> fault_o);
endmodule

bind task_slice_timer tst_checker #(.DIGITS(DIGITS)) u_tst_checker (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .intr_mode_i  (intr_mode_i),
    .irq_mask_i   (irq_mask_i),
    .load_i       (load_i),
    .load_val_i   (load_val_i),
    .proc_taken_i (proc_taken_i),
    .irq_o        (irq_o),
    .fault_o      (fault_o),
    .count_o      (count_o)
);

// File: tb/test_task_slice_timer.sv
module test_task_slice_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 26;

    typedef struct packed {
        logic        ld;
        logic [23:0] val;
        logic        tk;
        logic        im;
        logic        mk;
        logic        pt;
        logic [23:0] ecnt;
        logic        eirq;
        logic        eflt;
        logic [7:0]  req;
    } vec_t;

    // ld, val, tick, intr, mask, taken, exp count, exp irq, exp fault, req
    localparam vec_t VEC [NV] = '{
        '{1'b1, 24'h100000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h100000, 1'b0, 1'b0, 8'd2},  // R2 load
        '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 1'b0, 24'h099999, 1'b0, 1'b0, 8'd3},  // R3 borrow
        '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 1'b0, 24'h099998, 1'b0, 1'b0, 8'd8},  // R8 msd zero, masked
        '{1'b0, 24'h0,      1'b1, 1'b1, 1'b0, 1'b0, 24'h099998, 1'b0, 1'b0, 8'd4},  // R4 intr mode hold
        '{1'b1, 24'h000002, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000002, 1'b0, 1'b0, 8'd2},  // R2 load beats tick
        '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 1'b0, 24'h000001, 1'b0, 1'b0, 8'd3},  // R3
        '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 1'b0, 24'h000000, 1'b0, 1'b0, 8'd9},  // R9 fault lags
        '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 1'b0, 24'h000000, 1'b0, 1'b1, 8'd5},  // R5 saturate, R9 fault
        '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b0, 24'h000000, 1'b0, 1'b1, 8'd9},  // R9 sticky
        '{1'b1, 24'h000001, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000001, 1'b0, 1'b0, 8'd2},  // R2 load clears fault
        '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b1, 24'h000001, 1'b0, 1'b0, 8'd10}, // R10 taken
        '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 1'b0, 24'h000000, 1'b0, 1'b0, 8'd10}, // R10
        '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b0, 24'h000000, 1'b0, 1'b0, 8'd10}, // R10 no fault
        '{1'b1, 24'h100001, 1'b0, 1'b0, 1'b1, 1'b0, 24'h100001, 1'b0, 1'b0, 8'd2},  // R2
        '{1'b0, 24'h0,      1'b1, 1'b0, 1'b1, 1'b0, 24'h100000, 1'b0, 1'b0, 8'd6},  // R6
        '{1'b0, 24'h0,      1'b1, 1'b0, 1'b1, 1'b0, 24'h099999, 1'b0, 1'b0, 8'd6},  // R6 lag
        '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 1'b0, 24'h099999, 1'b1, 1'b0, 8'd6},  // R6 irq up
        '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 1'b0, 24'h099999, 1'b1, 1'b0, 8'd6},  // R6 level
        '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 1'b1, 24'h099999, 1'b0, 1'b0, 8'd7},  // R7 taken clears
        '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 1'b0, 24'h099999, 1'b0, 1'b0, 8'd7},  // R7 no re-raise
        '{1'b1, 24'h000500, 1'b1, 1'b0, 1'b1, 1'b0, 24'h000500, 1'b0, 1'b0, 8'd2},  // R2
        '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 1'b0, 24'h000500, 1'b1, 1'b0, 8'd6},  // R6 new slice
        '{1'b1, 24'h000500, 1'b0, 1'b0, 1'b1, 1'b0, 24'h000500, 1'b0, 1'b0, 8'd2},  // R2 load clears irq
        '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 1'b0, 24'h000500, 1'b1, 1'b0, 8'd6},  // R6
        '{1'b1, 24'h010000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h010000, 1'b0, 1'b0, 8'd2},  // R2
        '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 1'b0, 24'h009999, 1'b0, 1'b0, 8'd3}   // R3 borrow
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_i, intr_mode_i, irq_mask_i, load_i, proc_taken_i;
    logic [23:0] load_val_i;
    logic        irq_o, fault_o;
    logic [23:0] count_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    task_slice_timer i_task_slice_timer (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .intr_mode_i  (intr_mode_i),
        .irq_mask_i   (irq_mask_i),
        .load_i       (load_i),
        .load_val_i   (load_val_i),
        .proc_taken_i (proc_taken_i),
        .irq_o        (irq_o),
        .fault_o      (fault_o),
        .count_o      (count_o)
    );

    task automatic chk(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tick_i = 0; intr_mode_i = 0; irq_mask_i = 0;
        load_i = 0; load_val_i = '0; proc_taken_i = 0;
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("reset count", 1, {8'h0, count_o}, 32'h0);
        chk("reset irq",   1, {31'h0, irq_o},  32'h0);
        chk("reset fault", 1, {31'h0, fault_o}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            load_i       = VEC[i].ld;
            load_val_i   = VEC[i].val;
            tick_i       = VEC[i].tk;
            intr_mode_i  = VEC[i].im;
            irq_mask_i   = VEC[i].mk;
            proc_taken_i = VEC[i].pt;
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("row %0d count", i), VEC[i].req, {8'h0, count_o}, {8'h0, VEC[i].ecnt});
            chk($sformatf("row %0d irq", i),   VEC[i].req, {31'h0, irq_o},   {31'h0, VEC[i].eirq});
            chk($sformatf("row %0d fault", i), VEC[i].req, {31'h0, fault_o}, {31'h0, VEC[i].eflt});
        end

        // R1 reset in mid-run clears a loaded count and a raised irq
        idle_inputs();
        irq_mask_i = 1; load_i = 1; load_val_i = 24'h023456;
        @(posedge clk); @(negedge clk);
        load_i = 0;
        @(posedge clk); @(negedge clk);
        chk("irq before reset", 6, {31'h0, irq_o}, 32'h1);
        rst = 1;
        @(posedge clk); @(negedge clk);
        chk("mid reset count", 1, {8'h0, count_o}, 32'h0);
        chk("mid reset irq",   1, {31'h0, irq_o},  32'h0);
        rst = 0;

        // R5 long run to zero with intr-mode gaps, then saturation
        idle_inputs();
        load_i = 1; load_val_i = 24'h000012;
        @(posedge clk); @(negedge clk);
        load_i = 0;
        for (int k = 0; k < 30; k++) begin
            tick_i = 1;
            intr_mode_i = (k % 3 == 0);
            @(posedge clk); @(negedge clk);
        end
        idle_inputs();
        chk("saturated count", 5, {8'h0, count_o}, 32'h0);
        chk("fault after run", 9, {31'h0, fault_o}, 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule